// File: doc/BRIEF.md
# Calibrated Sample Word Formatter

This block takes one channel's 24-bit two's-complement conversion result and prepares it for a serial output. It subtracts a programmable offset from the result. It then scales the difference by a programmable unsigned gain. Finally it packs the corrected value into one of four output word layouts. A downstream serial shifter consumes the 32-bit word, together with the word-length code that applies to it.

The offset and the gain are each 24 bits wide. Each comes from two configuration registers: a 16-bit upper part that supplies bits 23:8, and an 8-bit byte that supplies bits 7:0. The gain is an unsigned fixed-point number with one integer bit and 23 fractional bits, so 800000h means exactly 1.0. With the register reset values (gain upper 8000h, gain byte 00h, offset 0) the sample passes through unchanged.

The datapath has two register stages. Stage one captures the difference, the gain and the word-length code together with the sample. Stage two multiplies, rounds, saturates, packs and registers the word. A sample presented with its strobe appears at the output two clock cycles later.

Top module: `cal_sample_fmt`

## Requirements
- R1: While reset is held and after it is released, before any sample arrives, `out_valid` is 0 and `out_word` is 0.
- R2: Each cycle with `in_valid` high produces exactly one cycle of `out_valid` high, two clock edges later. `out_valid` is never high otherwise.
- R3: The offset is the signed value {`ofs_upper`, `ofs_byte`}, with `ofs_upper` as bits 23:8. It is subtracted from the signed sample before gain is applied.
- R4: The gain is the unsigned value {`gain_upper`, `gain_byte`} with 23 fractional bits. The value 800000h is unity, so with offset 0 the sample passes through unchanged.
- R5: The scaled value is the full product shifted right arithmetically by 23 bits, which rounds toward negative infinity.
- R6: A scaled value above 7FFFFFh is clamped to 7FFFFFh, and one below -800000h is clamped to 800000h.
- R7: Code 00b (16-bit) gives `out_word` = {16 zero bits, corrected[23:8]}.
- R8: Code 01b (24-bit) gives `out_word` = {8 zero bits, corrected[23:0]}.
- R9: Code 10b (32-bit, padded) gives `out_word` = {corrected[23:0], 8 zero bits}.
- R10: Code 11b (32-bit, sign-extended) gives `out_word` = {8 copies of corrected[23], corrected[23:0]}.
- R11: `out_wlen` carries the code that was sampled with the same input sample. `out_word` and `out_wlen` hold their values in every cycle that does not deliver a new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe for a new raw sample |
| in_sample | input | 24 | Raw two's-complement conversion result |
| ofs_upper | input | 16 | Offset bits 23:8 |
| ofs_byte | input | 8 | Offset bits 7:0 |
| gain_upper | input | 16 | Gain bits 23:8 |
| gain_byte | input | 8 | Gain bits 7:0 |
| wlen_sel | input | 2 | Word-length code (00b 16, 01b 24, 10b 32 padded, 11b 32 sign-extended) |
| out_valid | output | 1 | One-cycle strobe for a new formatted word |
| out_word | output | 32 | Formatted output word |
| out_wlen | output | 2 | Word-length code that applies to `out_word` |

## Verification
The assertions check several properties on every clock cycle. They check the link between the two stage strobes and the output strobe. They check that the formatted word and code hold while no result is delivered. They check the layout invariants of the three non-24-bit modes: zero upper half, zero low byte, and a uniform sign byte. Only the bench scenarios, through their reference arithmetic, can show the correct numbers. This covers offset assembly and subtraction order, unity gain, floor rounding of negative products, and clamping at both rails.

// File: rtl/cal_fmt_pkg.sv
package cal_fmt_pkg;
    typedef enum logic [1:0] {
        WL_16      = 2'b00,
        WL_24      = 2'b01,
        WL_32_ZPAD = 2'b10,
        WL_32_SEXT = 2'b11
    } wlen_e;
endpackage

// File: rtl/cal_diff_stage.sv
module cal_diff_stage #(
    parameter int DATA_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   in_sample,
    input  logic [DATA_W-1:0]   ofs,
    input  logic [DATA_W-1:0]   gain,
    input  cal_fmt_pkg::wlen_e  wlen,
    output logic                s1_valid,
    output logic signed [DATA_W:0] s1_diff,
    output logic [DATA_W-1:0]   s1_gain,
    output cal_fmt_pkg::wlen_e  s1_wlen
);
    // Sign-extend both operands by one bit so the difference cannot wrap.
    logic signed [DATA_W:0] diff_c;

    always_comb begin
        diff_c = $signed({in_sample[DATA_W-1], in_sample}) - $signed({ofs[DATA_W-1], ofs});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_diff  <= '0;
            s1_gain  <= '0;
            s1_wlen  <= cal_fmt_pkg::WL_24;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_diff <= diff_c;
                s1_gain <= gain;
                s1_wlen <= wlen;
            end
        end
    end
endmodule

// File: rtl/cal_word_pack.sv
module cal_word_pack #(
    parameter int DATA_W  = 24,
    parameter int SHORT_W = 16,
    parameter int OUT_W   = 32
) (
    input  logic [DATA_W-1:0]  value,
    input  cal_fmt_pkg::wlen_e wlen,
    output logic [OUT_W-1:0]   word
);
    localparam int PAD_W   = OUT_W - DATA_W;
    localparam int SHPAD_W = OUT_W - SHORT_W;

    always_comb begin
        unique case (wlen)
            cal_fmt_pkg::WL_16:      word = {{SHPAD_W{1'b0}}, value[DATA_W-1 -: SHORT_W]};
            cal_fmt_pkg::WL_24:      word = {{PAD_W{1'b0}}, value};
            cal_fmt_pkg::WL_32_ZPAD: word = {value, {PAD_W{1'b0}}};
            cal_fmt_pkg::WL_32_SEXT: word = {{PAD_W{value[DATA_W-1]}}, value};
            default:                 word = '0;
        endcase
    end
endmodule

// File: rtl/cal_scale_stage.sv
module cal_scale_stage #(
    parameter int DATA_W  = 24,
    parameter int FRAC_W  = 23,
    parameter int SHORT_W = 16,
    parameter int OUT_W   = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   s1_valid,
    input  logic signed [DATA_W:0] s1_diff,
    input  logic [DATA_W-1:0]      s1_gain,
    input  cal_fmt_pkg::wlen_e     s1_wlen,
    output logic                   out_valid,
    output logic [OUT_W-1:0]       out_word,
    output logic [1:0]             out_wlen
);
    localparam int PROD_W = 2 * (DATA_W + 1);

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic [DATA_W-1:0]        clamped;
    logic                     fits;
    logic [OUT_W-1:0]         packed_w;

    always_comb begin
        prod   = PROD_W'(s1_diff * $signed({1'b0, s1_gain}));
        scaled = prod >>> FRAC_W;
        // In range when every bit from the top down to the result sign agrees.
        fits   = (&scaled[PROD_W-1:DATA_W-1]) | ~(|scaled[PROD_W-1:DATA_W-1]);
        if (fits)
            clamped = scaled[DATA_W-1:0];
        else if (scaled[PROD_W-1])
            clamped = {1'b1, {(DATA_W-1){1'b0}}};
        else
            clamped = {1'b0, {(DATA_W-1){1'b1}}};
    end

    cal_word_pack #(
        .DATA_W (DATA_W),
        .SHORT_W(SHORT_W),
        .OUT_W  (OUT_W)
    ) u_pack (
        .value(clamped),
        .wlen (s1_wlen),
        .word (packed_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_wlen  <= 2'b01;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_word <= packed_w;
                out_wlen <= s1_wlen;
            end
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> ($stable(out_word) && $stable(out_wlen))); // R11
    AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_wlen == 2'b00) |-> (out_word[OUT_W-1:SHORT_W] == '0)); // R7
    AST_ZPAD_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_wlen == 2'b10) |-> (out_word[OUT_W-DATA_W-1:0] == '0)); // R9
    AST_SEXT_UNIFORM: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_wlen == 2'b11) |->
        ((&out_word[OUT_W-1:DATA_W-1]) || !(|out_word[OUT_W-1:DATA_W-1]))); // R10
endmodule

// File: rtl/cal_sample_fmt.sv
module cal_sample_fmt #(
    parameter int DATA_W  = 24,
    parameter int HI_W    = 16,
    parameter int FRAC_W  = 23,
    parameter int SHORT_W = 16,
    parameter int OUT_W   = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   in_sample,
    input  logic [HI_W-1:0]     ofs_upper,
    input  logic [DATA_W-HI_W-1:0] ofs_byte,
    input  logic [HI_W-1:0]     gain_upper,
    input  logic [DATA_W-HI_W-1:0] gain_byte,
    input  logic [1:0]          wlen_sel,
    output logic                out_valid,
    output logic [OUT_W-1:0]    out_word,
    output logic [1:0]          out_wlen
);
    logic [DATA_W-1:0]      ofs_full;
    logic [DATA_W-1:0]      gain_full;
    cal_fmt_pkg::wlen_e     wlen_in;
    logic                   s1_valid;
    logic signed [DATA_W:0] s1_diff;
    logic [DATA_W-1:0]      s1_gain;
    cal_fmt_pkg::wlen_e     s1_wlen;

    assign ofs_full  = {ofs_upper, ofs_byte};
    assign gain_full = {gain_upper, gain_byte};
    assign wlen_in   = cal_fmt_pkg::wlen_e'(wlen_sel);

    cal_diff_stage #(.DATA_W(DATA_W)) u_diff (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sample(in_sample),
        .ofs      (ofs_full),
        .gain     (gain_full),
        .wlen     (wlen_in),
        .s1_valid (s1_valid),
        .s1_diff  (s1_diff),
        .s1_gain  (s1_gain),
        .s1_wlen  (s1_wlen)
    );

    cal_scale_stage #(
        .DATA_W (DATA_W),
        .FRAC_W (FRAC_W),
        .SHORT_W(SHORT_W),
        .OUT_W  (OUT_W)
    ) u_scale (
        .clk      (clk),
        .rst      (rst),
        .s1_valid (s1_valid),
        .s1_diff  (s1_diff),
        .s1_gain  (s1_gain),
        .s1_wlen  (s1_wlen),
        .out_valid(out_valid),
        .out_word (out_word),
        .out_wlen (out_wlen)
    );

    AST_STAGE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(s1_valid)); // R2
    AST_FIRST_STAGE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1_valid); // R2
endmodule

// File: tb/sim_cal_sample_fmt.sv
module sim_cal_sample_fmt;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [23:0] in_sample;
    logic [15:0] ofs_upper;
    logic [7:0]  ofs_byte;
    logic [15:0] gain_upper;
    logic [7:0]  gain_byte;
    logic [1:0]  wlen_sel;
    logic        out_valid;
    logic [31:0] out_word;
    logic [1:0]  out_wlen;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_sample_fmt u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .ofs_upper(ofs_upper), .ofs_byte(ofs_byte),
        .gain_upper(gain_upper), .gain_byte(gain_byte),
        .wlen_sel(wlen_sel), .out_valid(out_valid),
        .out_word(out_word), .out_wlen(out_wlen)
    );

    function automatic logic [31:0] ref_word(logic [23:0] raw, logic [23:0] ofs,
                                             logic [23:0] g, logic [1:0] wl);
        longint d;
        longint q;
        logic [23:0] v;
        d = longint'($signed(raw)) - longint'($signed(ofs));
        q = (d * longint'(g)) >>> 23;
        if (q > 64'sd8388607)  q = 64'sd8388607;
        if (q < -64'sd8388608) q = -64'sd8388608;
        v = q[23:0];
        case (wl)
            2'b00:   return {16'h0, v[23:8]};
            2'b01:   return {8'h0, v};
            2'b10:   return {v, 8'h0};
            default: return {{8{v[23]}}, v};
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; the result is sampled two rising edges later.
    task automatic apply(string req, logic [23:0] raw, logic [23:0] ofs,
                         logic [23:0] g, logic [1:0] wl);
        logic [31:0] exp;
        exp = ref_word(raw, ofs, g, wl);
        in_valid   = 1'b1;
        in_sample  = raw;
        ofs_upper  = ofs[23:8];
        ofs_byte   = ofs[7:0];
        gain_upper = g[23:8];
        gain_byte  = g[7:0];
        wlen_sel   = wl;
        @(negedge clk);
        in_valid  = 1'b0;
        in_sample = raw ^ 24'h5A5A5A;
        wlen_sel  = ~wl;
        @(negedge clk);
        check({req, " R2 valid"}, {31'h0, out_valid}, 32'h1);
        check(req, out_word, exp);
        check({req, " R11 code"}, {30'h0, out_wlen}, {30'h0, wl});
        @(negedge clk);
        check({req, " R2 single pulse"}, {31'h0, out_valid}, 32'h0);
        check({req, " R11 hold"}, out_word, exp);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; in_sample = '0;
        ofs_upper = '0; ofs_byte = '0; gain_upper = 16'h8000; gain_byte = '0;
        wlen_sel = 2'b01;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {31'h0, out_valid}, 32'h0);
        check("R1 word in reset", out_word, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", {31'h0, out_valid}, 32'h0);
        check("R1 word after reset", out_word, 32'h0);

        apply("R4 unity pass", 24'h123456, 24'h0, 24'h800000, 2'b01);
        apply("R4 unity neg", 24'hF00001, 24'h0, 24'h800000, 2'b01);
        apply("R3 offset", 24'h001000, 24'h000123, 24'h800000, 2'b01);
        apply("R3 offset byte", 24'h000000, 24'hFFFFFF, 24'h800000, 2'b01);
        apply("R3 order", 24'h100000, 24'h080000, 24'h400000, 2'b01);
        apply("R5 floor neg", 24'hFFFFFF, 24'h0, 24'h400000, 2'b01);
        apply("R5 floor pos", 24'h000003, 24'h0, 24'h400000, 2'b01);
        apply("R6 clamp high", 24'h7FFFFF, 24'h800000, 24'h800000, 2'b01);
        apply("R6 clamp low", 24'h800000, 24'h7FFFFF, 24'h800000, 2'b01);
        apply("R6 gain high", 24'h600000, 24'h0, 24'hFFFFFF, 2'b01);
        apply("R7 short", 24'h89ABCD, 24'h0, 24'h800000, 2'b00);
        apply("R8 mid", 24'h89ABCD, 24'h0, 24'h800000, 2'b01);
        apply("R9 padded", 24'h89ABCD, 24'h0, 24'h800000, 2'b10);
        apply("R10 sext neg", 24'h89ABCD, 24'h0, 24'h800000, 2'b11);
        apply("R10 sext pos", 24'h09ABCD, 24'h0, 24'h800000, 2'b11);
        apply("R6 zero gain", 24'h7FFFFF, 24'h0, 24'h000000, 2'b11);

        for (int i = 0; i < 60; i++) begin
            apply("R5 random", 24'($urandom), 24'($urandom), 24'($urandom), 2'($urandom));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule